// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This unit counts clock cycles and selected hardware events for software profiling. It holds one dedicated 32-bit cycle counter and `NUM_EVT` 32-bit event counters. Each event counter is given an 8-bit event type, which names one line of the `event_pulse` vector. A counter advances only when the global enable in the control register and its own enable bit are both set. When a counter passes all ones it wraps to zero and raises an overflow flag. A flag whose interrupt enable is set drives `irq`.

Software reaches the unit through a flat register port. Writes take effect at the clock edge. Read data is registered and appears one cycle after the address is presented. Counter enables and interrupt enables each have a pair of registers: one sets bits and the other clears them. Overflow flags are cleared by writing ones. The event counters are not addressed directly. Software writes an index into a selector register, and the event-type and event-count registers then act on the selected counter. The cycle counter has its own count register.

Register addresses (word index on `reg_addr`): 0 control, 1 enable-set, 2 enable-clear, 3 irq-enable-set, 4 irq-enable-clear, 5 overflow, 6 selector, 7 event type, 8 event count, 9 cycle count. Unmapped addresses read zero.

Top module: `perf_count_unit`

## Requirements
- R1: After synchronous reset, every counter, enable mask, interrupt-enable mask, overflow flag and the selector read zero, the global enable is clear and `irq` is low.
- R2: A write to a set register (addr 1 or 3) sets exactly the mask bits written as 1. A write to a clear register (addr 2 or 4) clears exactly those bits. Bits written as 0 keep their value. Reading either address of a pair returns the mask. Mask bits NUM_EVT..30 always read 0.
- R3: In the enable, interrupt-enable and overflow masks, bit 31 belongs to the cycle counter and bit i (i < NUM_EVT) belongs to event counter i.
- R4: Writing 1 to an overflow bit (addr 5) clears it. Bits written as 0 are unchanged, and writing all ones clears every flag.
- R5: Event type (addr 7) and event count (addr 8) read and write the event counter whose index is held in the selector (addr 6).
- R6: Every counter is 32 bits wide. On an increment from 0xFFFFFFFF it becomes 0 and sets its overflow bit.
- R7: The control register holds the global enable at bit 0, a read-only NUM_EVT at bits 12:8 and a read-only ID code at bits 31:24. All other bits read 0.
- R8: The cycle counter (addr 9) can be read and written. While the global enable and mask bit 31 are set, it advances by one on every clock. A software write to it takes priority over the increment.
- R9: Event counter i advances by one in each cycle in which the global enable and mask bit i are set and `event_pulse[type_i]` is high. Pulses on other codes do not move it.
- R10: `irq` is high exactly when some overflow bit and its matching interrupt-enable bit are both set. It stays high until that flag or enable is cleared.
- R11: With a selector value of NUM_EVT or more, event type and event count read 0, and writes to them change no counter.
- R12: If a counter wraps in the same cycle that software writes 1 to clear its overflow bit, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register word address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| event_pulse | input | EVT_CODES | One-cycle event pulses, one bit per event code |
| irq | output | 1 | Registered overflow interrupt |

## Verification
The hardest case to reach is a counter wrapping in exactly the cycle that software clears its overflow flag. The bench first presets an event counter to all ones through the selector. It then drives the matching event pulse and the overflow clear write on the same clock, after which the flag must still read as set. Event counting is checked by running two differently typed counters under seeded random pulse vectors and comparing each against a tally the bench keeps of its own code. The cycle counter is checked over windows of a known length, bounded by writes to the global enable.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W  = 32;
  localparam int TYPE_W  = 8;
  localparam int CYC_BIT = 31;

  localparam logic [3:0] A_CTRL    = 4'd0;
  localparam logic [3:0] A_CEN_SET = 4'd1;
  localparam logic [3:0] A_CEN_CLR = 4'd2;
  localparam logic [3:0] A_IEN_SET = 4'd3;
  localparam logic [3:0] A_IEN_CLR = 4'd4;
  localparam logic [3:0] A_OVF     = 4'd5;
  localparam logic [3:0] A_SEL     = 4'd6;
  localparam logic [3:0] A_ETYPE   = 4'd7;
  localparam logic [3:0] A_ECNT    = 4'd8;
  localparam logic [3:0] A_CCNT    = 4'd9;
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count,
  output logic         wrap
);
  always_ff @(posedge clk) begin
    if (rst)        count <= '0;
    else if (wr_en) count <= wr_data;
    else if (inc)   count <= count + 1'b1;
  end

  // a software write replaces the increment, so it cannot wrap
  assign wrap = inc & ~wr_en & (&count);
endmodule

// File: rtl/pmu_event_select.sv
module pmu_event_select #(
  parameter int CODES  = 16,
  parameter int TYPE_W = 8
) (
  input  logic [CODES-1:0]  pulses,
  input  logic [TYPE_W-1:0] ev_type,
  output logic              hit
);
  always_comb begin
    hit = 1'b0;
    for (int c = 0; c < CODES; c++) begin
      if (ev_type == TYPE_W'(c)) hit = hit | pulses[c];
    end
  end
endmodule

// File: rtl/perf_count_unit.sv
module perf_count_unit
  import pmu_pkg::*;
#(
  parameter int          NUM_EVT   = 4,
  parameter int          EVT_CODES = 16,
  parameter int          ADDR_W    = 4,
  parameter logic [7:0]  ID_CODE   = 8'hA7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [EVT_CODES-1:0] event_pulse,
  output logic                 irq
);
  localparam int          IDX_W      = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
  localparam logic [31:0] VALID_MASK = 32'h8000_0000 | ((32'h1 << NUM_EVT) - 32'h1);

  logic              ctrl_en_q;
  logic [31:0]       cnt_en_q, int_en_q, ovf_q;
  logic [31:0]       cnt_en_n, int_en_n, ovf_n;
  logic [TYPE_W-1:0] sel_q;
  logic [TYPE_W-1:0] evt_type_q [NUM_EVT];
  logic [31:0]       evt_count  [NUM_EVT];
  logic [NUM_EVT-1:0] evt_wrap, evt_hit, evt_wr;
  logic [31:0]       cyc_count;
  logic              cyc_wrap, cyc_wr;
  logic [31:0]       wrap_vec;
  logic              sel_ok;
  logic [IDX_W-1:0]  sel_idx;
  logic [31:0]       rd_next;

  function automatic logic is_wr(input logic w, input logic [ADDR_W-1:0] a,
                                 input logic [3:0] target);
    return w && (a == ADDR_W'(target));
  endfunction

  assign sel_ok  = (sel_q < TYPE_W'(NUM_EVT));
  assign sel_idx = sel_q[IDX_W-1:0];
  assign cyc_wr  = is_wr(reg_wr, reg_addr, A_CCNT);

  // control and selector
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en_q <= 1'b0;
      sel_q     <= '0;
    end else begin
      if (is_wr(reg_wr, reg_addr, A_CTRL)) ctrl_en_q <= reg_wdata[0];
      if (is_wr(reg_wr, reg_addr, A_SEL))  sel_q     <= reg_wdata[TYPE_W-1:0];
    end
  end

  // event counter slots
  genvar i;
  generate
    for (i = 0; i < NUM_EVT; i++) begin : g_evt
      logic type_wr;
      assign type_wr   = is_wr(reg_wr, reg_addr, A_ETYPE) && sel_ok && (sel_q == TYPE_W'(i));
      assign evt_wr[i] = is_wr(reg_wr, reg_addr, A_ECNT)  && sel_ok && (sel_q == TYPE_W'(i));

      always_ff @(posedge clk) begin
        if (rst)          evt_type_q[i] <= '0;
        else if (type_wr) evt_type_q[i] <= reg_wdata[TYPE_W-1:0];
      end

      pmu_event_select #(.CODES(EVT_CODES), .TYPE_W(TYPE_W)) u_sel (
        .pulses  (event_pulse),
        .ev_type (evt_type_q[i]),
        .hit     (evt_hit[i])
      );

      pmu_counter #(.W(DATA_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc     (ctrl_en_q & cnt_en_q[i] & evt_hit[i]),
        .wr_en   (evt_wr[i]),
        .wr_data (reg_wdata),
        .count   (evt_count[i]),
        .wrap    (evt_wrap[i])
      );
    end
  endgenerate

  pmu_counter #(.W(DATA_W)) u_cyc (
    .clk     (clk),
    .rst     (rst),
    .inc     (ctrl_en_q & cnt_en_q[CYC_BIT]),
    .wr_en   (cyc_wr),
    .wr_data (reg_wdata),
    .count   (cyc_count),
    .wrap    (cyc_wrap)
  );

  always_comb begin
    wrap_vec          = '0;
    wrap_vec[NUM_EVT-1:0] = evt_wrap;
    wrap_vec[CYC_BIT] = cyc_wrap;
  end

  // mask next-state: set/clear pairs and write-one-to-clear flags
  always_comb begin
    cnt_en_n = cnt_en_q;
    int_en_n = int_en_q;
    if (is_wr(reg_wr, reg_addr, A_CEN_SET)) cnt_en_n = cnt_en_n | reg_wdata;
    if (is_wr(reg_wr, reg_addr, A_CEN_CLR)) cnt_en_n = cnt_en_n & ~reg_wdata;
    if (is_wr(reg_wr, reg_addr, A_IEN_SET)) int_en_n = int_en_n | reg_wdata;
    if (is_wr(reg_wr, reg_addr, A_IEN_CLR)) int_en_n = int_en_n & ~reg_wdata;
    cnt_en_n = cnt_en_n & VALID_MASK;
    int_en_n = int_en_n & VALID_MASK;

    ovf_n = ovf_q;
    if (is_wr(reg_wr, reg_addr, A_OVF)) ovf_n = ovf_n & ~reg_wdata;
    ovf_n = (ovf_n | wrap_vec) & VALID_MASK;   // a fresh wrap beats the clear
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_en_q <= '0;
      int_en_q <= '0;
      ovf_q    <= '0;
      irq      <= 1'b0;
    end else begin
      cnt_en_q <= cnt_en_n;
      int_en_q <= int_en_n;
      ovf_q    <= ovf_n;
      irq      <= |(ovf_n & int_en_n);
    end
  end

  // registered read port
  always_comb begin
    rd_next = '0;
    case (reg_addr)
      ADDR_W'(A_CTRL):    rd_next = {ID_CODE, 11'd0, 5'(NUM_EVT), 7'd0, ctrl_en_q};
      ADDR_W'(A_CEN_SET),
      ADDR_W'(A_CEN_CLR): rd_next = cnt_en_q;
      ADDR_W'(A_IEN_SET),
      ADDR_W'(A_IEN_CLR): rd_next = int_en_q;
      ADDR_W'(A_OVF):     rd_next = ovf_q;
      ADDR_W'(A_SEL):     rd_next = 32'(sel_q);
      ADDR_W'(A_ETYPE):   rd_next = sel_ok ? 32'(evt_type_q[sel_idx]) : 32'd0;
      ADDR_W'(A_ECNT):    rd_next = sel_ok ? evt_count[sel_idx] : 32'd0;
      ADDR_W'(A_CCNT):    rd_next = cyc_count;
      default:            rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
  parameter int NUM_EVT = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               irq,
  input logic               ctrl_en_q,
  input logic [31:0]        cnt_en_q,
  input logic [31:0]        int_en_q,
  input logic [31:0]        ovf_q,
  input logic [7:0]         sel_q,
  input logic [NUM_EVT-1:0] evt_wr,
  input logic               cyc_wrap,
  input logic               cyc_wr,
  input logic [31:0]        cyc_count
);
  localparam logic [31:0] VALID_MASK = 32'h8000_0000 | ((32'h1 << NUM_EVT) - 32'h1);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (cnt_en_q == 32'd0 && int_en_q == 32'd0 && ovf_q == 32'd0 && !ctrl_en_q && !irq));

  // R2
  mask_bits_chk: assert property (@(posedge clk) disable iff (rst)
    ((cnt_en_q | int_en_q | ovf_q) & ~VALID_MASK) == 32'd0);

  // R10
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (|(ovf_q & int_en_q)));

  // R12
  wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_wrap |=> ovf_q[31]);

  // R8
  cyc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_en_q && cnt_en_q[31] && !cyc_wr) |=> cyc_count == $past(cyc_count) + 32'd1);

  // R11
  sel_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q >= 8'(NUM_EVT)) |-> (evt_wr == '0));
endmodule

bind perf_count_unit pmu_checker #(.NUM_EVT(NUM_EVT)) u_pmu_chk (
  .clk       (clk),
  .rst       (rst),
  .irq       (irq),
  .ctrl_en_q (ctrl_en_q),
  .cnt_en_q  (cnt_en_q),
  .int_en_q  (int_en_q),
  .ovf_q     (ovf_q),
  .sel_q     (sel_q),
  .evt_wr    (evt_wr),
  .cyc_wrap  (cyc_wrap),
  .cyc_wr    (cyc_wr),
  .cyc_count (cyc_count)
);

// File: tb/test_perf_count_unit.sv
`timescale 1ns/1ps
module test_perf_count_unit;
  localparam int         NUM_EVT   = 4;
  localparam int         EVT_CODES = 16;
  localparam logic [7:0] ID_CODE   = 8'hA7;
  localparam logic [31:0] VALID    = 32'h8000_000F;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [3:0]           reg_addr = '0;
  logic                 reg_wr = 1'b0;
  logic [31:0]          reg_wdata = '0;
  logic [31:0]          reg_rdata;
  logic [EVT_CODES-1:0] event_pulse = '0;
  logic                 irq;

  int checks = 0;
  int errors = 0;
  int seed_dummy;

  always #5 clk = ~clk;

  perf_count_unit #(.NUM_EVT(NUM_EVT), .EVT_CODES(EVT_CODES), .ADDR_W(4), .ID_CODE(ID_CODE))
    i_perf_count_unit (
      .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .event_pulse(event_pulse), .irq(irq));

  function automatic logic [31:0] exp_ctrl(input logic en);
    return {ID_CODE, 11'd0, 5'(NUM_EVT), 7'd0, en};
  endfunction

  function automatic logic [31:0] exp_mask(input logic [31:0] prev, input logic [31:0] set,
                                           input logic [31:0] clr);
    return ((prev | set) & ~clr) & VALID;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // callers sit at a negedge; each access spans one rising edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; reg_wr = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, m;
    int exp0, exp1;
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state, R7 control fields
    rd(4'd0, v); chk("R7 ctrl after reset", v, exp_ctrl(1'b0));
    rd(4'd1, v); chk("R1 enable mask", v, 32'd0);
    rd(4'd5, v); chk("R1 overflow", v, 32'd0);
    rd(4'd9, v); chk("R1 cycle count", v, 32'd0);
    rd(4'd6, v); chk("R1 selector", v, 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);

    // R2 set/clear pairs, R3 implemented bits
    wr(4'd1, 32'hFFFF_FFFF); rd(4'd2, v);
    m = exp_mask(32'd0, 32'hFFFF_FFFF, 32'd0);
    chk("R3 enable bits 31 and 0..N-1", v, m);
    wr(4'd2, 32'h0000_0005); rd(4'd1, v);
    m = exp_mask(m, 32'd0, 32'h5);
    chk("R2 clear only ones", v, m);
    wr(4'd1, 32'h0000_0001); rd(4'd1, v);
    m = exp_mask(m, 32'h1, 32'd0);
    chk("R2 set only ones", v, m);
    wr(4'd3, 32'h8000_0002); wr(4'd4, 32'h0000_0002); rd(4'd3, v);
    chk("R2 irq enable pair", v, 32'h8000_0000);
    wr(4'd4, 32'hFFFF_FFFF);

    // R7 global enable bit round trip
    wr(4'd0, 32'hFFFF_FFFF); rd(4'd0, v); chk("R7 ctrl enable", v, exp_ctrl(1'b1));
    wr(4'd0, 32'd0);

    // R5 indirect access, R11 out-of-range selector
    wr(4'd6, 32'd0); wr(4'd7, 32'd5);
    wr(4'd6, 32'd1); wr(4'd7, 32'd3); wr(4'd8, 32'd0);
    wr(4'd6, 32'd2); wr(4'd7, 32'd9); wr(4'd8, 32'h1234_5678);
    wr(4'd6, 32'd0); rd(4'd7, v); chk("R5 type of counter 0", v, 32'd5);
    wr(4'd8, 32'd0);
    wr(4'd6, 32'd2); rd(4'd8, v); chk("R5 count of counter 2", v, 32'h1234_5678);
    wr(4'd6, 32'd4); wr(4'd7, 32'h11); wr(4'd8, 32'h55);
    rd(4'd7, v); chk("R11 type reads zero", v, 32'd0);
    rd(4'd8, v); chk("R11 count reads zero", v, 32'd0);
    for (int k = 0; k < NUM_EVT; k++) begin
      wr(4'd6, 32'(k)); rd(4'd8, v);
      chk("R11 no counter changed", v, (k == 2) ? 32'h1234_5678 : 32'd0);
    end

    // R8 cycle counter direct access and exact window
    wr(4'd9, 32'd100); rd(4'd9, v); chk("R8 cycle write", v, 32'd100);
    wr(4'd0, 32'd1);
    repeat (9) @(negedge clk);
    wr(4'd0, 32'd0);
    rd(4'd9, v); chk("R8 cycle window", v, 32'd110);

    // R9 random events on two typed counters (0:code5, 1:code3)
    wr(4'd0, 32'd1);
    exp0 = 0; exp1 = 0;
    for (int k = 0; k < 80; k++) begin
      event_pulse = EVT_CODES'($urandom);
      exp0 += int'(event_pulse[5]);
      exp1 += int'(event_pulse[3]);
      @(negedge clk);
    end
    event_pulse = '0;
    wr(4'd0, 32'd0);
    wr(4'd6, 32'd0); rd(4'd8, v); chk("R9 counter 0 code 5", v, 32'(exp0));
    wr(4'd6, 32'd1); rd(4'd8, v); chk("R9 counter 1 code 3", v, 32'(exp1));
    wr(4'd6, 32'd2); rd(4'd8, v); chk("R9 disabled counter held", v, 32'h1234_5678);

    // R6 cycle wrap, R10 irq
    wr(4'd5, 32'hFFFF_FFFF);
    wr(4'd9, 32'hFFFF_FFFE);
    wr(4'd0, 32'd1);
    repeat (1) @(negedge clk);
    wr(4'd0, 32'd0);
    rd(4'd9, v); chk("R6 cycle wraps to zero", v, 32'd0);
    rd(4'd5, v); chk("R6 overflow bit 31", v, 32'h8000_0000);
    chk("R10 irq masked", 32'(irq), 32'd0);
    wr(4'd3, 32'h8000_0000);
    chk("R10 irq raised", 32'(irq), 32'd1);
    wr(4'd5, 32'h0000_0001);
    chk("R4 zero bit leaves flag", 32'(irq), 32'd1);
    wr(4'd5, 32'h8000_0000);
    chk("R10 irq dropped on clear", 32'(irq), 32'd0);
    rd(4'd5, v); chk("R4 flag cleared", v, 32'd0);

    // R12 wrap on the clearing cycle (event counter 0, code 5)
    wr(4'd1, 32'h0000_0003); wr(4'd2, 32'h8000_0000);
    wr(4'd6, 32'd0); wr(4'd8, 32'hFFFF_FFFF);
    wr(4'd0, 32'd1);
    event_pulse = 16'h0020; @(negedge clk); event_pulse = '0;
    rd(4'd5, v); chk("R6 event wrap flag", v, 32'h0000_0001);
    rd(4'd8, v); chk("R6 event wraps to zero", v, 32'd0);
    wr(4'd8, 32'hFFFF_FFFF);
    event_pulse = 16'h0020;
    wr(4'd5, 32'h0000_0001);
    event_pulse = '0;
    rd(4'd5, v); chk("R12 flag survives clear", v, 32'h0000_0001);
    wr(4'd3, 32'h0000_0001);
    chk("R10 irq on event flag", 32'(irq), 32'd1);
    wr(4'd4, 32'h0000_0001);
    chk("R10 irq off when enable cleared", 32'(irq), 32'd0);
    wr(4'd5, 32'hFFFF_FFFF);
    rd(4'd5, v); chk("R4 all ones clears", v, 32'd0);
    wr(4'd0, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule